// File: doc/BRIEF.md
# TLB Fill Index Selector and Entry Writer

This block turns a TLB fill request into a single write command for the TLB storage. The storage is made of two regions. One is a set-associative region for small pages, 8 ways of 256 lines. The other is a fully associative region of 64 entries that may hold any page size. For a random fill, the block compares the requested page size with the configured small-region page size and picks the region. It derives the line number from the virtual page bits and takes the way, or the slot in the large region, from a free-running LFSR.

The block also serves indexed writes. An indexed write either fills the entry named by the index register or, when the not-exist flag is set, clears only that entry's exist bit. The source fields come from one of two register sets: the normal set, or the refill set while a refill is in progress.

The write command goes out on registered ports one cycle after the request. The storage is outside this block, so every field the block decides can be seen at the ports.

Top module: `tlbfill_writer`

## Requirements
- R1: After synchronous reset `rst`, `wrDone`, `wrIdx`, `wrFull`, `wrExist` and `wrPsEn` are all 0.
- R2: On a random fill (`fillReq`=1), the target is the small region (index 0..2047) when the selected source page size equals `smallPs`. Otherwise the target is the large region (index 2048..2111).
- R3: For a small-region target, line = ((srcVppn << 13) >> (smallPs+1)) & 0xFF. The written index is way*256 + line.
- R4: The LFSR is 16 bits wide. It resets to 0xACE1 and on every clock after reset it becomes {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]}. A fill strobe sampled at an edge uses the LFSR value held just before that edge. The way is lfsr[2:0], and a large-region index is 2048 + (lfsr mod 64).
- R5: A fill writes `wrFull`=1, `wrExist`=1, the source VPPN, `wrAsid`=`curAsid`, and both source entry-lo words unchanged.
- R6: On a full write, `wrPsEn`=1 and `wrPs` = source page size only when the target index is 2048 or above. For other full writes, `wrPsEn`=0 and `wrPs`=0.
- R7: When `inRefill`=1, VPPN, page size and entry-lo words come from the refill inputs. When `inRefill`=0, they come from the normal inputs.
- R8: An indexed write (`idxWrReq`=1, `fillReq`=0) with `idxNe`=1 gives `wrIdx`=`idxIndex`, `wrFull`=0 and `wrExist`=0, with every other data output 0.
- R9: An indexed write with `idxNe`=0 writes all fields as in R5 at `wrIdx`=`idxIndex`.
- R10: `wrDone` is high for exactly the one cycle after each cycle in which a request is sampled, and is low otherwise.
- R11: When `fillReq` and `idxWrReq` are both high, the random fill is performed and the indexed write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fillReq | input | 1 | Random fill strobe |
| idxWrReq | input | 1 | Indexed write strobe |
| inRefill | input | 1 | Selects the refill source set |
| normVppn | input | 35 | Normal entry-hi virtual page pair number |
| normPs | input | 6 | Normal page size (from the index register) |
| normLo0 | input | 64 | Normal even-page entry-lo |
| normLo1 | input | 64 | Normal odd-page entry-lo |
| idxIndex | input | 12 | Entry index for indexed writes |
| idxNe | input | 1 | Not-exist flag for indexed writes |
| refillVppn | input | 35 | Refill entry-hi virtual page pair number |
| refillPs | input | 6 | Refill page size |
| refillLo0 | input | 64 | Refill even-page entry-lo |
| refillLo1 | input | 64 | Refill odd-page entry-lo |
| smallPs | input | 6 | Page size of the small region |
| curAsid | input | 10 | Current address space ID |
| wrDone | output | 1 | Write strobe / done pulse |
| wrIdx | output | 12 | Target entry index |
| wrFull | output | 1 | 1 = write all fields, 0 = exist bit only |
| wrExist | output | 1 | Exist bit value |
| wrPsEn | output | 1 | Page size field is written |
| wrPs | output | 6 | Page size value |
| wrVppn | output | 35 | VPPN value |
| wrAsid | output | 10 | ASID value |
| wrLo0 | output | 64 | Even-page entry-lo value |
| wrLo1 | output | 64 | Odd-page entry-lo value |

## Verification
The bench uses the default parameters: 8 ways, 256 lines, 64 large entries, a 35-bit VPPN and 64-bit entry-lo words. With these values the boundary between the two regions sits at index 2048, and small page sizes of 8, 12 and 14 give line numbers that are shifted left, taken straight from the VPPN, and shifted right. The bench keeps its own model of the 16-bit LFSR, so every random way and every large-region slot can be predicted exactly.

// File: rtl/tlbfill_pkg.sv
package tlbfill_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic doWrite;    // register a write command this cycle
    logic useRandom;  // random fill (else indexed)
    logic toSmall;    // random fill targets small region
    logic clearOnly;  // indexed clear of exist bit only
  } fillCtl_t;
endpackage

// File: rtl/tlbfill_lfsr.sv
module tlbfill_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] lfsrVal
);
  logic feedback;
  assign feedback = ^(lfsrVal & TAPS);

  always_ff @(posedge clk) begin
    if (rst) lfsrVal <= SEED;
    else     lfsrVal <= {lfsrVal[W-2:0], feedback};
  end
endmodule

// File: rtl/tlbfill_ctrl.sv
module tlbfill_ctrl
  import tlbfill_pkg::*;
(
  input  logic     fillReq,
  input  logic     idxWrReq,
  input  logic     idxNe,
  input  logic     psMatch,
  output fillCtl_t ctl
);
  always_comb begin
    ctl.doWrite   = fillReq | idxWrReq;
    ctl.useRandom = fillReq;
    ctl.toSmall   = fillReq & psMatch;
    ctl.clearOnly = ~fillReq & idxWrReq & idxNe;
  end
endmodule

// File: rtl/tlbfill_dp.sv
module tlbfill_dp
  import tlbfill_pkg::*;
#(
  parameter int WAYS     = 8,
  parameter int LINES    = 256,
  parameter int MULTI    = 64,
  parameter int VPPN_W   = 35,
  parameter int PS_W     = 6,
  parameter int ASID_W   = 10,
  parameter int LO_W     = 64,
  parameter int PAGE_LSB = 13,
  parameter int LFSR_W   = 16,
  parameter int IDX_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  fillCtl_t          ctl,
  input  logic [LFSR_W-1:0] lfsrVal,
  input  logic              inRefill,
  input  logic [VPPN_W-1:0] normVppn,
  input  logic [PS_W-1:0]   normPs,
  input  logic [LO_W-1:0]   normLo0,
  input  logic [LO_W-1:0]   normLo1,
  input  logic [IDX_W-1:0]  idxIndex,
  input  logic [VPPN_W-1:0] refillVppn,
  input  logic [PS_W-1:0]   refillPs,
  input  logic [LO_W-1:0]   refillLo0,
  input  logic [LO_W-1:0]   refillLo1,
  input  logic [PS_W-1:0]   smallPs,
  input  logic [ASID_W-1:0] curAsid,
  output logic              psMatch,
  output logic              wrDone,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              wrFull,
  output logic              wrExist,
  output logic              wrPsEn,
  output logic [PS_W-1:0]   wrPs,
  output logic [VPPN_W-1:0] wrVppn,
  output logic [ASID_W-1:0] wrAsid,
  output logic [LO_W-1:0]   wrLo0,
  output logic [LO_W-1:0]   wrLo1
);
  localparam int SMALL_N = WAYS * LINES;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LINE_W  = $clog2(LINES);
  localparam int VA_W    = VPPN_W + PAGE_LSB;

  logic [VPPN_W-1:0] srcVppn;
  logic [PS_W-1:0]   srcPs;
  logic [LO_W-1:0]   srcLo0, srcLo1;
  logic [VA_W-1:0]   vaFull;
  logic [PS_W:0]     shAmt;
  logic [LINE_W-1:0] lineNum;
  logic [WAY_W-1:0]  wayNum;
  logic [IDX_W-1:0]  idxSmall, idxMulti, tgtIdx;
  logic              tgtMulti;

  // Source register set selection
  always_comb begin
    srcVppn = inRefill ? refillVppn : normVppn;
    srcPs   = inRefill ? refillPs   : normPs;
    srcLo0  = inRefill ? refillLo0  : normLo0;
    srcLo1  = inRefill ? refillLo1  : normLo1;
  end

  assign psMatch = (srcPs == smallPs);

  // Line number from VA bits above the page pair
  assign vaFull  = {srcVppn, {PAGE_LSB{1'b0}}};
  assign shAmt   = {1'b0, smallPs} + {{PS_W{1'b0}}, 1'b1};
  assign lineNum = LINE_W'(vaFull >> shAmt);
  assign wayNum  = lfsrVal[WAY_W-1:0];

  assign idxSmall = IDX_W'(wayNum) * IDX_W'(LINES) + IDX_W'(lineNum);
  assign idxMulti = IDX_W'(SMALL_N) + IDX_W'(lfsrVal % LFSR_W'(MULTI));

  always_comb begin
    if (ctl.useRandom) tgtIdx = ctl.toSmall ? idxSmall : idxMulti;
    else               tgtIdx = idxIndex;
  end
  assign tgtMulti = (tgtIdx >= IDX_W'(SMALL_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      wrDone  <= 1'b0;
      wrIdx   <= '0;
      wrFull  <= 1'b0;
      wrExist <= 1'b0;
      wrPsEn  <= 1'b0;
      wrPs    <= '0;
      wrVppn  <= '0;
      wrAsid  <= '0;
      wrLo0   <= '0;
      wrLo1   <= '0;
    end else begin
      wrDone <= ctl.doWrite;
      if (ctl.doWrite) begin
        wrIdx <= tgtIdx;
        if (ctl.clearOnly) begin
          wrFull  <= 1'b0;
          wrExist <= 1'b0;
          wrPsEn  <= 1'b0;
          wrPs    <= '0;
          wrVppn  <= '0;
          wrAsid  <= '0;
          wrLo0   <= '0;
          wrLo1   <= '0;
        end else begin
          wrFull  <= 1'b1;
          wrExist <= 1'b1;
          wrPsEn  <= tgtMulti;
          wrPs    <= tgtMulti ? srcPs : '0;
          wrVppn  <= srcVppn;
          wrAsid  <= curAsid;
          wrLo0   <= srcLo0;
          wrLo1   <= srcLo1;
        end
      end
    end
  end
endmodule

// File: rtl/tlbfill_writer.sv
module tlbfill_writer
  import tlbfill_pkg::*;
#(
  parameter int WAYS     = 8,
  parameter int LINES    = 256,
  parameter int MULTI    = 64,
  parameter int VPPN_W   = 35,
  parameter int PS_W     = 6,
  parameter int ASID_W   = 10,
  parameter int LO_W     = 64,
  parameter int PAGE_LSB = 13,
  localparam int IDX_W   = $clog2(WAYS * LINES + MULTI)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fillReq,
  input  logic              idxWrReq,
  input  logic              inRefill,
  input  logic [VPPN_W-1:0] normVppn,
  input  logic [PS_W-1:0]   normPs,
  input  logic [LO_W-1:0]   normLo0,
  input  logic [LO_W-1:0]   normLo1,
  input  logic [IDX_W-1:0]  idxIndex,
  input  logic              idxNe,
  input  logic [VPPN_W-1:0] refillVppn,
  input  logic [PS_W-1:0]   refillPs,
  input  logic [LO_W-1:0]   refillLo0,
  input  logic [LO_W-1:0]   refillLo1,
  input  logic [PS_W-1:0]   smallPs,
  input  logic [ASID_W-1:0] curAsid,
  output logic              wrDone,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              wrFull,
  output logic              wrExist,
  output logic              wrPsEn,
  output logic [PS_W-1:0]   wrPs,
  output logic [VPPN_W-1:0] wrVppn,
  output logic [ASID_W-1:0] wrAsid,
  output logic [LO_W-1:0]   wrLo0,
  output logic [LO_W-1:0]   wrLo1
);
  localparam int LFSR_W = 16;

  fillCtl_t          ctl;
  logic              psMatch;
  logic [LFSR_W-1:0] lfsrVal;

  tlbfill_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .lfsrVal(lfsrVal)
  );

  tlbfill_ctrl u_ctrl (
    .fillReq(fillReq), .idxWrReq(idxWrReq), .idxNe(idxNe),
    .psMatch(psMatch), .ctl(ctl)
  );

  tlbfill_dp #(
    .WAYS(WAYS), .LINES(LINES), .MULTI(MULTI), .VPPN_W(VPPN_W),
    .PS_W(PS_W), .ASID_W(ASID_W), .LO_W(LO_W), .PAGE_LSB(PAGE_LSB),
    .LFSR_W(LFSR_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .lfsrVal(lfsrVal),
    .inRefill(inRefill), .normVppn(normVppn), .normPs(normPs),
    .normLo0(normLo0), .normLo1(normLo1), .idxIndex(idxIndex),
    .refillVppn(refillVppn), .refillPs(refillPs),
    .refillLo0(refillLo0), .refillLo1(refillLo1),
    .smallPs(smallPs), .curAsid(curAsid), .psMatch(psMatch),
    .wrDone(wrDone), .wrIdx(wrIdx), .wrFull(wrFull), .wrExist(wrExist),
    .wrPsEn(wrPsEn), .wrPs(wrPs), .wrVppn(wrVppn), .wrAsid(wrAsid),
    .wrLo0(wrLo0), .wrLo1(wrLo1)
  );
endmodule

// File: rtl/tlbfill_chk.sv
module tlbfill_chk #(
  parameter int WAYS   = 8,
  parameter int LINES  = 256,
  parameter int MULTI  = 64,
  parameter int PS_W   = 6,
  parameter int ASID_W = 10,
  parameter int IDX_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              fillReq,
  input logic              idxWrReq,
  input logic              idxNe,
  input logic              inRefill,
  input logic [PS_W-1:0]   normPs,
  input logic [PS_W-1:0]   refillPs,
  input logic [PS_W-1:0]   smallPs,
  input logic [ASID_W-1:0] curAsid,
  input logic              wrDone,
  input logic [IDX_W-1:0]  wrIdx,
  input logic              wrFull,
  input logic              wrExist,
  input logic              wrPsEn,
  input logic [ASID_W-1:0] wrAsid
);
  localparam int SMALL_N = WAYS * LINES;
  localparam int TOTAL   = SMALL_N + MULTI;

  logic [PS_W-1:0] selPs;
  assign selPs = inRefill ? refillPs : normPs;

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (fillReq || idxWrReq) |=> wrDone); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !(fillReq || idxWrReq) |=> !wrDone); // R10
  AST_SMALL_TARGET: assert property (@(posedge clk) disable iff (rst)
    (fillReq && selPs == smallPs) |=> (wrIdx < IDX_W'(SMALL_N))); // R2
  AST_MULTI_TARGET: assert property (@(posedge clk) disable iff (rst)
    (fillReq && selPs != smallPs) |=> (wrIdx >= IDX_W'(SMALL_N) && wrIdx < IDX_W'(TOTAL))); // R2
  AST_FILL_ASID: assert property (@(posedge clk) disable iff (rst)
    fillReq |=> (wrFull && wrExist && wrAsid == $past(curAsid))); // R5
  AST_PSEN_MULTI_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wrDone && wrPsEn) |-> (wrIdx >= IDX_W'(SMALL_N))); // R6
  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (idxWrReq && idxNe && !fillReq) |=> (!wrFull && !wrExist && !wrPsEn)); // R8
  AST_FILL_WINS: assert property (@(posedge clk) disable iff (rst)
    (fillReq && idxWrReq) |=> wrFull); // R11
endmodule

bind tlbfill_writer tlbfill_chk #(
  .WAYS(WAYS), .LINES(LINES), .MULTI(MULTI), .PS_W(PS_W),
  .ASID_W(ASID_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .fillReq(fillReq), .idxWrReq(idxWrReq),
  .idxNe(idxNe), .inRefill(inRefill), .normPs(normPs),
  .refillPs(refillPs), .smallPs(smallPs), .curAsid(curAsid),
  .wrDone(wrDone), .wrIdx(wrIdx), .wrFull(wrFull), .wrExist(wrExist),
  .wrPsEn(wrPsEn), .wrAsid(wrAsid)
);

// File: tb/tb_tlbfill_writer.sv
module tb_tlbfill_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fillReq = 0, idxWrReq = 0, inRefill = 0, idxNe = 0;
  logic [34:0] normVppn = 0, refillVppn = 0;
  logic [5:0]  normPs = 0, refillPs = 0, smallPs = 6'd12;
  logic [63:0] normLo0 = 0, normLo1 = 0, refillLo0 = 0, refillLo1 = 0;
  logic [11:0] idxIndex = 0;
  logic [9:0]  curAsid = 0;
  logic        wrDone, wrFull, wrExist, wrPsEn;
  logic [11:0] wrIdx;
  logic [5:0]  wrPs;
  logic [34:0] wrVppn;
  logic [9:0]  wrAsid;
  logic [63:0] wrLo0, wrLo1;

  int checks = 0, failures = 0;
  logic [15:0] modelLfsr, lfsrAtReq;

  always #10 clk = ~clk;  // 50 MHz

  tlbfill_writer dut (
    .clk(clk), .rst(rst), .fillReq(fillReq), .idxWrReq(idxWrReq),
    .inRefill(inRefill), .normVppn(normVppn), .normPs(normPs),
    .normLo0(normLo0), .normLo1(normLo1), .idxIndex(idxIndex),
    .idxNe(idxNe), .refillVppn(refillVppn), .refillPs(refillPs),
    .refillLo0(refillLo0), .refillLo1(refillLo1), .smallPs(smallPs),
    .curAsid(curAsid), .wrDone(wrDone), .wrIdx(wrIdx), .wrFull(wrFull),
    .wrExist(wrExist), .wrPsEn(wrPsEn), .wrPs(wrPs), .wrVppn(wrVppn),
    .wrAsid(wrAsid), .wrLo0(wrLo0), .wrLo1(wrLo1)
  );

  // Independent LFSR model per R4
  always_ff @(posedge clk) begin
    if (rst) modelLfsr <= 16'hACE1;
    else     modelLfsr <= {modelLfsr[14:0], modelLfsr[15] ^ modelLfsr[13] ^ modelLfsr[12] ^ modelLfsr[10]};
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] expLine(logic [34:0] vppn, logic [5:0] ps);
    logic [47:0] va;
    va = {vppn, 13'b0};
    return 12'((va >> (int'(ps) + 1)) & 48'hFF);
  endfunction

  // Called at a negedge: pulse strobes, return at the negedge after the result is registered
  task automatic fire(logic f, logic w);
    fillReq = f; idxWrReq = w;
    lfsrAtReq = modelLfsr;
    @(posedge clk);
    @(negedge clk);
    fillReq = 0; idxWrReq = 0;
  endtask

  task automatic pulseEnds();
    @(negedge clk);
    chk("R10 done single pulse", 64'(wrDone), 64'd0);
  endtask

  task automatic testReset();
    chk("R1 reset wrDone", 64'(wrDone), 0);
    chk("R1 reset wrIdx", 64'(wrIdx), 0);
    chk("R1 reset wrFull", 64'(wrFull), 0);
    chk("R1 reset wrExist", 64'(wrExist), 0);
    chk("R1 reset wrPsEn", 64'(wrPsEn), 0);
  endtask

  task automatic testSmallFill(logic [34:0] vppn, logic [5:0] sps);
    logic [11:0] exp;
    inRefill = 0; smallPs = sps; normPs = sps; normVppn = vppn;
    normLo0 = {29'h0, vppn} ^ 64'h1111_0000_0000_0001;
    normLo1 = 64'hFEED_0000_0000_0002; curAsid = 10'h2A5;
    fire(1, 0);
    exp = 12'(lfsrAtReq[2:0]) * 12'd256 + expLine(vppn, sps);
    chk("R10 done after fill", 64'(wrDone), 1);
    chk("R2 R3 R4 small index", 64'(wrIdx), 64'(exp));
    chk("R5 exist", 64'(wrExist), 1);
    chk("R5 full", 64'(wrFull), 1);
    chk("R5 vppn", 64'(wrVppn), 64'(vppn));
    chk("R5 asid", 64'(wrAsid), 64'h2A5);
    chk("R5 lo0", wrLo0, {29'h0, vppn} ^ 64'h1111_0000_0000_0001);
    chk("R5 lo1", wrLo1, 64'hFEED_0000_0000_0002);
    chk("R6 small psEn", 64'(wrPsEn), 0);
    chk("R6 small ps", 64'(wrPs), 0);
    pulseEnds();
  endtask

  task automatic testMultiFill(logic [5:0] reqPs);
    inRefill = 0; smallPs = 6'd12; normPs = reqPs; normVppn = 35'h1234;
    curAsid = 10'h011;
    fire(1, 0);
    chk("R2 R4 multi index", 64'(wrIdx), 64'(12'd2048 + 12'(lfsrAtReq % 16'd64)));
    chk("R6 multi psEn", 64'(wrPsEn), 1);
    chk("R6 multi ps", 64'(wrPs), 64'(reqPs));
    chk("R5 multi asid", 64'(wrAsid), 64'h011);
    pulseEnds();
  endtask

  task automatic testRefillSource();
    // normal set would mismatch smallPs; refill set matches it
    smallPs = 6'd12; normPs = 6'd21; normVppn = 35'h0AAAA; normLo0 = 64'h1; normLo1 = 64'h2;
    refillPs = 6'd12; refillVppn = 35'h0BB37; refillLo0 = 64'hA0A0; refillLo1 = 64'hB0B0;
    inRefill = 1;
    fire(1, 0);
    chk("R7 refill small index", 64'(wrIdx),
        64'(12'(lfsrAtReq[2:0]) * 12'd256 + expLine(35'h0BB37, 6'd12)));
    chk("R7 refill vppn", 64'(wrVppn), 64'h0BB37);
    chk("R7 refill lo0", wrLo0, 64'hA0A0);
    chk("R7 refill lo1", wrLo1, 64'hB0B0);
    pulseEnds();
    inRefill = 0;
    fire(1, 0);
    chk("R7 normal source vppn", 64'(wrVppn), 64'h0AAAA);
    chk("R7 normal source multi", 64'(wrPsEn), 1);
    chk("R7 normal lo0", wrLo0, 64'h1);
    pulseEnds();
  endtask

  task automatic testIndexed();
    inRefill = 0; normVppn = 35'h7777; normPs = 6'd16; normLo0 = 64'h55; normLo1 = 64'h66;
    curAsid = 10'h3FF;
    idxIndex = 12'd300; idxNe = 1;
    fire(0, 1);
    chk("R8 clear index", 64'(wrIdx), 300);
    chk("R8 clear full", 64'(wrFull), 0);
    chk("R8 clear exist", 64'(wrExist), 0);
    chk("R8 clear vppn", 64'(wrVppn), 0);
    chk("R8 clear lo0", wrLo0, 0);
    chk("R8 clear asid", 64'(wrAsid), 0);
    chk("R8 clear psEn", 64'(wrPsEn), 0);
    pulseEnds();
    idxNe = 0; idxIndex = 12'd5;
    fire(0, 1);
    chk("R9 indexed small idx", 64'(wrIdx), 5);
    chk("R9 indexed exist", 64'(wrExist), 1);
    chk("R9 indexed vppn", 64'(wrVppn), 64'h7777);
    chk("R9 R6 indexed small psEn", 64'(wrPsEn), 0);
    pulseEnds();
    idxIndex = 12'd2100;
    fire(0, 1);
    chk("R9 indexed multi idx", 64'(wrIdx), 2100);
    chk("R9 R6 indexed multi psEn", 64'(wrPsEn), 1);
    chk("R9 R6 indexed multi ps", 64'(wrPs), 16);
    chk("R9 indexed asid", 64'(wrAsid), 64'h3FF);
    pulseEnds();
  endtask

  task automatic testBoth();
    inRefill = 0; smallPs = 6'd12; normPs = 6'd12; normVppn = 35'h00042;
    idxIndex = 12'd2090; idxNe = 1;
    fire(1, 1);
    chk("R11 fill wins full", 64'(wrFull), 1);
    chk("R11 fill wins index", 64'(wrIdx),
        64'(12'(lfsrAtReq[2:0]) * 12'd256 + 12'h42));
    pulseEnds();
    idxNe = 0;
  endtask

  task automatic testIdle();
    repeat (3) @(negedge clk);
    chk("R10 idle no done", 64'(wrDone), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 0;
    @(negedge clk);
    testSmallFill(35'h0_1234_56AB, 6'd12);
    testSmallFill(35'h0_0000_03F5, 6'd14);
    testSmallFill(35'h0_0000_00E9, 6'd8);
    for (int i = 0; i < 4; i++) testSmallFill(35'(i * 37 + 5), 6'd12);
    testMultiFill(6'd21);
    testMultiFill(6'd0);
    testRefillSource();
    testIndexed();
    testBoth();
    testIdle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule